// File: doc/BRIEF.md
# Banked Credit Bitmap with Emulated Bit Writes

This block keeps a credit bitmap of 2048 rows by 16 bits, one row per flow group and one bit per credit slot. The storage is two 8-bit-wide synchronous memories that can only write whole words. A single-bit change is therefore done inside the block: the 8-bit word is read, the named bit is merged in, and the whole word is written back.

Three request ports share the table. A credit-arrival port sets one bit. A consume port clears one bit. A lookup port returns a whole 16-bit row one cycle after it is accepted, so a caller can test all credit slots of a flow group in one access. Bits 0 to 7 of a row live in the low bank and bits 8 to 15 in the high bank. Each bank has its own small queue of pending bit updates and its own sequencer. Work in one bank therefore overlaps with work in the other.

Each bank sequencer is a two-state machine. In IDLE no word read is outstanding. In MERGE the read data for an update returns, the bit is merged and the word is written back. The **issue** transition leads from either state into MERGE when the bank queue holds an update and no lookup claims the read port in that cycle. The **settle** transition leads from either state into IDLE otherwise. A lookup that has just been accepted, or an update read issued in the same cycle as a write-back to the same row, takes the word being written instead of the stale memory word.

Top module: `credit_bitmap_top`

## Requirements
- R1: After reset every bit of every row reads as zero.
- R2: An accepted credit-arrival request (valid and ready high at a rising edge) sets bit `cred_bit` of row `cred_row` and leaves the other 15 bits of that row unchanged.
- R3: A lookup accepted at a rising edge (lk_valid and lk_ready high) raises `lk_rvalid` after the next rising edge. `lk_data` bit i then holds credit bit i of row `lk_row`. `lk_rvalid` is low in every cycle that follows no accepted lookup.
- R4: An accepted consume request clears bit `use_bit` of row `use_row` and leaves the other bits unchanged.
- R5: Bit positions 0–7 (bit index bit 3 = 0) belong to the low bank and 8–15 (bit index bit 3 = 1) to the high bank. A credit-arrival request for one bank and a consume request for the other bank are both accepted in the same cycle when both queues have room.
- R6: Updates accepted in consecutive cycles for the same row and bank all take effect. None is lost to a write-back still in flight.
- R7: Each bank queues 4 pending updates. While a bank's queue is full, the ready of every port that targets that bank is low.
- R8: Lookups take the memory read port ahead of queued updates. Once an update has been blocked for 8 consecutive cycles, `lk_ready` goes low until that update reads. Every accepted update is seen by lookups accepted 64 or more cycles later.
- R9: When both update ports target the same bank in the same cycle, the credit-arrival request is taken and `use_ready` is low, so the consume request has no effect in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cred_valid | input | 1 | Credit-arrival request valid |
| cred_ready | output | 1 | Credit-arrival request can be taken |
| cred_row | input | 11 | Row of the credit to set |
| cred_bit | input | 4 | Bit position to set |
| use_valid | input | 1 | Consume request valid |
| use_ready | output | 1 | Consume request can be taken |
| use_row | input | 11 | Row of the credit to clear |
| use_bit | input | 4 | Bit position to clear |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup can be taken |
| lk_row | input | 11 | Row to read |
| lk_rvalid | output | 1 | Lookup result valid |
| lk_data | output | 16 | Full credit row returned |

## Verification
A wrong merge or a missed forward leaves a corrupted word in memory. It stays hidden until a later lookup of that row, and then shows as a row value that disagrees with a 2048-row reference. The bench issues bursts of updates over a few hot rows, so that forwarding hazards are common. It then checks every row once the 64-cycle completion bound has passed. A broken lookup-priority or starvation guard shows within about ten cycles as `lk_ready` never falling, or as an update still missing after the bound. A wrong queue-full limit shows within five cycles of back-to-back pushes into one bank.

// File: rtl/credit_bitmap_pkg.sv
package credit_bitmap_pkg;
    localparam int CB_ROWS   = 2048;
    localparam int CB_WIDTH  = 16;
    localparam int CB_BANK_W = 8;
    localparam int CB_BANKS  = CB_WIDTH / CB_BANK_W;
    localparam int CB_ROW_W  = $clog2(CB_ROWS);
    localparam int CB_BIT_W  = $clog2(CB_WIDTH);
    localparam int CB_LANE_W = $clog2(CB_BANK_W);
    localparam int CB_SEL_W  = (CB_BANKS > 1) ? $clog2(CB_BANKS) : 1;

    typedef struct packed {
        logic [CB_ROW_W-1:0]  row;
        logic [CB_LANE_W-1:0] lane;
        logic                 set;
    } cb_upd_t;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_MERGE = 1'b1
    } cb_state_e;
endpackage

// File: rtl/credit_bitmap_fifo.sv
module credit_bitmap_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     slot_q [DEPTH];
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [CNT_W-1:0] cnt_q;

    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign empty = (cnt_q == '0);
    assign dout  = slot_q[rd_q];

    always_ff @(posedge clk) begin
        if (push) slot_q[wr_q] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= (wr_q == PTR_W'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            if (pop)  rd_q <= (rd_q == PTR_W'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/credit_bitmap_bank.sv
module credit_bitmap_bank
    import credit_bitmap_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int AGE_MAX = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push,
    input  cb_upd_t              push_req,
    output logic                 ready,
    input  logic                 lk_fire,
    input  logic [CB_ROW_W-1:0]  lk_row,
    output logic [CB_BANK_W-1:0] lk_word,
    output logic                 hold_lk
);
    localparam int AGE_W = $clog2(AGE_MAX + 1);

    cb_state_e state_q, state_d;
    cb_upd_t   head, op_q;
    logic      full, empty, rmw_issue;
    logic [AGE_W-1:0] age_q;

    logic [CB_BANK_W-1:0] mem [CB_ROWS];
    logic [CB_ROWS-1:0]   written_q;
    logic [CB_BANK_W-1:0] rdata_q, fwd_data_q, word, wdata;
    logic                 rflag_q, fwd_q, we;
    logic [CB_ROW_W-1:0]  raddr;

    credit_bitmap_fifo #(.DEPTH(DEPTH), .W($bits(cb_upd_t))) u_queue (
        .clk(clk), .rst_n(rst_n), .push(push), .din(push_req),
        .pop(rmw_issue), .dout(head), .full(full), .empty(empty)
    );

    assign ready     = !full;
    assign hold_lk   = (age_q >= AGE_W'(AGE_MAX));
    assign rmw_issue = !empty && !lk_fire;
    assign raddr     = lk_fire ? lk_row : head.row;

    // Read data as seen one cycle after the read: a same-cycle write wins.
    assign word    = fwd_q ? fwd_data_q : (rflag_q ? rdata_q : '0);
    assign lk_word = word;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= '0;
            age_q   <= '0;
        end else begin
            state_q <= state_d;
            if (rmw_issue) op_q <= head;
            if (empty || rmw_issue) age_q <= '0;
            else if (!hold_lk)      age_q <= age_q + 1'b1;
        end
    end

    // Next state and outputs
    always_comb begin
        state_d = rmw_issue ? S_MERGE : S_IDLE;
        we      = 1'b0;
        wdata   = word;
        unique case (state_q)
            S_IDLE: begin
                we = 1'b0;
            end
            S_MERGE: begin
                we    = 1'b1;
                wdata = op_q.set ? (word | (CB_BANK_W'(1) << op_q.lane))
                                 : (word & ~(CB_BANK_W'(1) << op_q.lane));
            end
        endcase
    end

    // Word-only memory with one read and one write port
    always_ff @(posedge clk) begin
        if (we) mem[op_q.row] <= wdata;
        rdata_q    <= mem[raddr];
        fwd_data_q <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            written_q <= '0;
            rflag_q   <= 1'b0;
            fwd_q     <= 1'b0;
        end else begin
            if (we) written_q[op_q.row] <= 1'b1;
            rflag_q <= written_q[raddr];
            fwd_q   <= we && (op_q.row == raddr);
        end
    end

    assert_update_not_starved_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_lk && !empty) |=> (state_q == S_MERGE));
    assert_lookup_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        hold_lk |-> !lk_fire);
endmodule

// File: rtl/credit_bitmap_top.sv
module credit_bitmap_top
    import credit_bitmap_pkg::*;
#(
    parameter int QUEUE_DEPTH = 4,
    parameter int AGE_MAX     = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cred_valid,
    output logic                cred_ready,
    input  logic [CB_ROW_W-1:0] cred_row,
    input  logic [CB_BIT_W-1:0] cred_bit,
    input  logic                use_valid,
    output logic                use_ready,
    input  logic [CB_ROW_W-1:0] use_row,
    input  logic [CB_BIT_W-1:0] use_bit,
    input  logic                lk_valid,
    output logic                lk_ready,
    input  logic [CB_ROW_W-1:0] lk_row,
    output logic                lk_rvalid,
    output logic [CB_WIDTH-1:0] lk_data
);
    logic [CB_BANKS-1:0] bank_ready, bank_hold;
    logic [CB_SEL_W-1:0] cred_sel, use_sel;
    logic                lk_fire, lk_rvalid_q;

    assign cred_sel   = CB_SEL_W'(cred_bit >> CB_LANE_W);
    assign use_sel    = CB_SEL_W'(use_bit >> CB_LANE_W);
    assign lk_ready   = ~|bank_hold;
    assign lk_fire    = lk_valid && lk_ready;
    assign cred_ready = bank_ready[cred_sel];
    assign use_ready  = bank_ready[use_sel] && !(cred_valid && cred_sel == use_sel);
    assign lk_rvalid  = lk_rvalid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lk_rvalid_q <= 1'b0;
        else        lk_rvalid_q <= lk_fire;
    end

    for (genvar b = 0; b < CB_BANKS; b++) begin : g_bank
        logic    cred_hit, use_hit, push;
        cb_upd_t req;

        assign cred_hit = cred_valid && (cred_sel == CB_SEL_W'(b)) && cred_ready;
        assign use_hit  = use_valid && (use_sel == CB_SEL_W'(b)) && use_ready;
        assign push     = cred_hit || use_hit;
        assign req      = cred_hit
            ? '{row: cred_row, lane: cred_bit[CB_LANE_W-1:0], set: 1'b1}
            : '{row: use_row,  lane: use_bit[CB_LANE_W-1:0],  set: 1'b0};

        credit_bitmap_bank #(.DEPTH(QUEUE_DEPTH), .AGE_MAX(AGE_MAX)) u_bank (
            .clk(clk), .rst_n(rst_n), .push(push), .push_req(req),
            .ready(bank_ready[b]), .lk_fire(lk_fire), .lk_row(lk_row),
            .lk_word(lk_data[b*CB_BANK_W +: CB_BANK_W]), .hold_lk(bank_hold[b])
        );
    end

    assert_lookup_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lk_rvalid |-> $past(lk_valid && lk_ready));
    assert_lookup_answered_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lk_ready) |=> lk_rvalid);
endmodule

// File: tb/tb_credit_bitmap_top.sv
module tb_credit_bitmap_top;
    localparam int ROWS  = 2048;
    localparam int QUIET = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cred_valid = 0, use_valid = 0, lk_valid = 0;
    logic        cred_ready, use_ready, lk_ready, lk_rvalid;
    logic [10:0] cred_row = '0, use_row = '0, lk_row = '0;
    logic [3:0]  cred_bit = '0, use_bit = '0;
    logic [15:0] lk_data;

    int checks = 0, fails = 0, cyc = 0, wd = 0;
    logic [15:0] ref_tab [ROWS];
    int          last_acc [ROWS];
    bit c_f, u_f, l_f, c_r, u_r, l_r;

    always #10 clk = ~clk;

    credit_bitmap_top dut (
        .clk(clk), .rst_n(rst_n),
        .cred_valid(cred_valid), .cred_ready(cred_ready), .cred_row(cred_row), .cred_bit(cred_bit),
        .use_valid(use_valid), .use_ready(use_ready), .use_row(use_row), .use_bit(use_bit),
        .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_row(lk_row),
        .lk_rvalid(lk_rvalid), .lk_data(lk_data)
    );

    function automatic logic [15:0] apply_bit(logic [15:0] w, int b, bit set);
        return set ? (w | (16'h1 << b)) : (w & ~(16'h1 << b));
    endfunction

    task automatic check(bit ok, string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [10:0] hot_row();
        int k = $urandom_range(0, 7);
        if (k == 6) return 11'd2047;
        if (k == 7) return 11'd1024;
        return 11'(k);
    endfunction

    // One cycle: drive at negedge, settle, note acceptances, clock, check lookup.
    task automatic step(bit cv, int cr, int cb, bit uv, int ur, int ub, bit lv, int lr, string tag);
        bit quiet;
        logic [15:0] exp;
        cred_valid = cv; cred_row = 11'(cr); cred_bit = 4'(cb);
        use_valid = uv;  use_row = 11'(ur);  use_bit = 4'(ub);
        lk_valid = lv;   lk_row = 11'(lr);
        #1;
        c_r = cred_ready; u_r = use_ready; l_r = lk_ready;
        c_f = cv && cred_ready; u_f = uv && use_ready; l_f = lv && lk_ready;
        if (c_f) begin ref_tab[cr] = apply_bit(ref_tab[cr], cb, 1'b1); last_acc[cr] = cyc; end
        if (u_f) begin ref_tab[ur] = apply_bit(ref_tab[ur], ub, 1'b0); last_acc[ur] = cyc; end
        quiet = (cyc - last_acc[lr]) >= QUIET;
        exp = ref_tab[lr];
        @(posedge clk);
        cyc++;
        @(negedge clk);
        if (l_f) begin
            check(lk_rvalid === 1'b1, "R3 rvalid", {15'd0, lk_rvalid}, 16'd1);
            if (quiet) check(lk_data === exp, tag, lk_data, exp);
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
    endtask

    task automatic look(int r, string tag);
        step(0, 0, 0, 0, 0, 0, 1, r, tag);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        bit saw_full, saw_hold;
        void'($urandom(32'd20240611));
        for (int i = 0; i < ROWS; i++) begin ref_tab[i] = '0; last_acc[i] = -1000; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset contents and idle outputs
        check(lk_rvalid === 1'b0, "R3 idle rvalid", {15'd0, lk_rvalid}, 16'd0);
        check(cred_ready === 1'b1, "R7 reset ready", {15'd0, cred_ready}, 16'd1);
        look(0, "R1 row0");
        look(2047, "R1 row2047");
        look(777, "R1 row777");

        // R2 / R4: set three bits, then clear one
        step(1, 3, 0, 0, 0, 0, 0, 0, "R2");
        step(1, 3, 9, 0, 0, 0, 0, 0, "R2");
        step(1, 3, 15, 0, 0, 0, 0, 0, "R2");
        idle(QUIET);
        look(3, "R2 set bits");
        check(ref_tab[3] === 16'h8201, "R2 model", ref_tab[3], 16'h8201);
        step(0, 0, 0, 1, 3, 9, 0, 0, "R4");
        idle(QUIET);
        look(3, "R4 clear bit");

        // R5: both banks accept in the same cycle
        step(1, 10, 2, 1, 10, 12, 0, 0, "R5");
        check(c_f && u_f, "R5 dual accept", {14'd0, c_f, u_f}, 16'h3);
        idle(QUIET);
        look(10, "R5 row10");

        // R9: same-bank conflict, consume ignored
        step(1, 11, 3, 0, 0, 0, 0, 0, "R9");
        idle(QUIET);
        step(1, 11, 1, 1, 11, 3, 0, 0, "R9");
        check(c_r === 1'b1 && u_r === 1'b0, "R9 ready split", {14'd0, c_r, u_r}, 16'h2);
        idle(QUIET);
        look(11, "R9 consume had no effect");

        // R6: back-to-back same row and bank
        step(1, 20, 0, 0, 0, 0, 0, 0, "R6");
        step(1, 20, 1, 0, 0, 0, 0, 0, "R6");
        step(1, 20, 2, 0, 0, 0, 0, 0, "R6");
        step(1, 20, 3, 0, 0, 0, 0, 0, "R6");
        step(0, 0, 0, 1, 20, 1, 0, 0, "R6");
        idle(QUIET);
        look(20, "R6 no lost update");
        check(ref_tab[20] === 16'h000D, "R6 model", ref_tab[20], 16'h000D);

        // R7 / R8: continuous lookups starve the queue until the guard acts
        saw_full = 0; saw_hold = 0;
        for (int i = 0; i < 30; i++) begin
            step(1, 30, i % 8, 0, 0, 0, 1, 0, "R8 busy");
            if (!c_r) saw_full = 1;
            if (!l_r) saw_hold = 1;
        end
        check(saw_full, "R7 queue full drops ready", {15'd0, saw_full}, 16'd1);
        check(saw_hold, "R8 lookup held for update", {15'd0, saw_hold}, 16'd1);
        idle(QUIET);
        look(30, "R8 updates completed");
        look(0, "R8 row0");

        // Random traffic over hot rows, then quiet lookups
        for (int round = 0; round < 15; round++) begin
            for (int i = 0; i < 150; i++) begin
                int lr_ = hot_row();
                bit lv_ = ($urandom_range(0, 9) < 6);
                bit cv_ = ($urandom_range(0, 3) != 0);
                bit uv_ = ($urandom_range(0, 2) != 0);
                step(cv_, hot_row(), $urandom_range(0, 15), uv_, hot_row(), $urandom_range(0, 15),
                     lv_ && lk_ready, lr_, "R6 random");
            end
            for (int i = 0; i < QUIET + 24; i++) begin
                int lr_ = hot_row();
                step(0, 0, 0, 0, 0, 0, 1, lr_, (i < QUIET) ? "R8 drain" : "R2 R4 random");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule